// File: doc/BRIEF.md
# Predicated Vector Execution Unit

This block is a compact vector execution engine. It owns eight vector registers of 64 elements each, with 64 bits per element. It also owns a length register that limits how many leading elements an instruction processes, and a 64-bit mask register that can gate arithmetic writes. A controller issues one instruction at a time by placing an opcode, a destination register, two source registers, an element index and a 64-bit scalar on the inputs and pulsing `start`.

The unit then works through the active elements, a fixed number of lanes per clock. It supports element-wise add and multiply, an unsigned greater-than compare against the scalar that fills the mask, unsigned min, max and sum folds into a scalar result, and an index-driven gather within a register. It also has scalar-side helpers to set the length, to insert one element and to extract one element. A one-cycle `done` pulse marks the end of each instruction.

Top module: `vpu_core`

## Requirements
- R1: After synchronous reset, `busy` and `done` are 0, `scalar_res` is 0, `mask_out` is 0 and `vl_out` is 64.
- R2: Opcode 7 sets the length register to the scalar operand, saturating at 64 when the operand is larger; the length changes only through this opcode.
- R3: Opcodes 0 (add) and 1 (multiply, low 64 bits kept) write vd[i] = vs1[i] op vs2[i] for every i below the length; elements at or above the length keep their contents, and a length of 0 changes nothing.
- R4: With `pred` = 1, opcodes 0 and 1 write only elements whose mask bit is 1; the other elements keep their previous contents.
- R5: Opcode 2 sets mask bit i to (vs1[i] > scalar, unsigned) for every i below the length; mask bits at or above the length keep their value.
- R6: Opcodes 3, 4 and 5 fold elements 0 to length-1 of vs1 into `scalar_res` as the unsigned minimum, the unsigned maximum and the sum modulo 2^64. With a length of 0 the result is all ones for minimum and 0 for maximum and sum.
- R7: Opcode 6 writes vd[i] = vs1[vs2[i]] for every i below the length when the 64-bit index vs2[i] is below the length, and writes 0 otherwise.
- R8: Opcode 8 writes the scalar into element `eidx` of vd regardless of the length. Opcode 9 copies element `eidx` of vs1 to `scalar_res`.
- R9: A vector opcode (0 to 6) accepted at clock edge E keeps `busy` high until edge E+N, where N = ceil(length/4), or 1 when the length is 0. Opcodes 7 to 9 use N = 1. `done` is high for exactly the one cycle after edge E+N.
- R10: A `start` pulse seen while `busy` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Issue strobe, taken only while idle |
| op | input | 4 | Opcode (0 add, 1 mul, 2 compare, 3 min, 4 max, 5 sum, 6 gather, 7 set length, 8 insert, 9 extract) |
| pred | input | 1 | Gate add/mul writes with the mask |
| vd | input | 3 | Destination vector register |
| vs1 | input | 3 | First source vector register |
| vs2 | input | 3 | Second source or index vector register |
| eidx | input | 6 | Element index for insert and extract |
| scalar_in | input | 64 | Scalar operand |
| busy | output | 1 | Instruction in progress |
| done | output | 1 | One-cycle completion pulse |
| scalar_res | output | 64 | Fold or extract result |
| vl_out | output | 7 | Current vector length |
| mask_out | output | 64 | Current mask register |

## Verification
Every result lands at the edge that ends the instruction. Vector registers are written chunk by chunk, and `scalar_res`, the mask and the length are all settled when `done` rises, which is N edges after the issuing edge (N from R9). The bench drives inputs on falling edges. It counts falling edges from the issue until `done` is seen and compares that count with N computed from the length. Only after that does it read `scalar_res`, `mask_out` and `vl_out`, or extract register elements, so no value is sampled before its edge has passed.

// File: rtl/vpu_pkg.sv
package vpu_pkg;

    localparam int NUM_VREG = 8;
    localparam int NUM_ELEM = 64;
    localparam int ELEM_W   = 64;
    localparam int VREG_AW  = $clog2(NUM_VREG);
    localparam int EIDX_W   = $clog2(NUM_ELEM);
    localparam int VL_W     = $clog2(NUM_ELEM + 1);

    typedef enum logic [3:0] {
        OP_VADD   = 4'd0,
        OP_VMUL   = 4'd1,
        OP_CMPGT  = 4'd2,
        OP_RMIN   = 4'd3,
        OP_RMAX   = 4'd4,
        OP_RSUM   = 4'd5,
        OP_GATHER = 4'd6,
        OP_SETLEN = 4'd7,
        OP_INS    = 4'd8,
        OP_EXT    = 4'd9
    } vop_e;

    typedef struct packed {
        vop_e                op;
        logic                pred;
        logic [VREG_AW-1:0]  vd;
        logic [VREG_AW-1:0]  vs1;
        logic [VREG_AW-1:0]  vs2;
        logic [EIDX_W-1:0]   eidx;
        logic [ELEM_W-1:0]   sc;
    } vinstr_t;

    function automatic logic is_vector_op(input vop_e o);
        return (o == OP_VADD) || (o == OP_VMUL) || (o == OP_CMPGT) ||
               (o == OP_RMIN) || (o == OP_RMAX) || (o == OP_RSUM) ||
               (o == OP_GATHER);
    endfunction

    function automatic logic is_fold_op(input vop_e o);
        return (o == OP_RMIN) || (o == OP_RMAX) || (o == OP_RSUM);
    endfunction

    // Starting accumulator value for each fold
    function automatic logic [ELEM_W-1:0] fold_seed(input vop_e o);
        return (o == OP_RMIN) ? '1 : '0;
    endfunction

    function automatic logic [ELEM_W-1:0] fold_step(input vop_e o,
                                                     input logic [ELEM_W-1:0] acc,
                                                     input logic [ELEM_W-1:0] v);
        case (o)
            OP_RMIN: return (v < acc) ? v : acc;
            OP_RMAX: return (v > acc) ? v : acc;
            default: return acc + v;
        endcase
    endfunction

endpackage

// File: rtl/vpu_regfile.sv
module vpu_regfile #(
    parameter int LANES = 4,
    parameter int AW    = 9,
    parameter int DW    = 64,
    parameter int DEPTH = 512
) (
    input  logic                       clk,
    input  logic [LANES-1:0][AW-1:0]   ra_a,
    input  logic [LANES-1:0][AW-1:0]   ra_b,
    input  logic [LANES-1:0][AW-1:0]   ra_c,
    output logic [LANES-1:0][DW-1:0]   rd_a,
    output logic [LANES-1:0][DW-1:0]   rd_b,
    output logic [LANES-1:0][DW-1:0]   rd_c,
    input  logic [LANES-1:0]           we,
    input  logic [LANES-1:0][AW-1:0]   wa,
    input  logic [LANES-1:0][DW-1:0]   wd
);
    logic [DW-1:0] mem [DEPTH];

    always_comb begin
        for (int l = 0; l < LANES; l++) begin
            rd_a[l] = mem[ra_a[l]];
            rd_b[l] = mem[ra_b[l]];
            rd_c[l] = mem[ra_c[l]];
        end
    end

    always_ff @(posedge clk) begin
        for (int l = 0; l < LANES; l++) begin
            if (we[l]) mem[wa[l]] <= wd[l];
        end
    end
endmodule

// File: rtl/vpu_lane.sv
module vpu_lane
    import vpu_pkg::*;
(
    input  vop_e              op,
    input  logic              pred,
    input  logic              active,
    input  logic              mask_bit,
    input  logic [ELEM_W-1:0] src_a,
    input  logic [ELEM_W-1:0] src_b,
    input  logic [ELEM_W-1:0] gath_val,
    input  logic              idx_ok,
    input  logic [ELEM_W-1:0] scalar,
    output logic              wr_en,
    output logic [ELEM_W-1:0] wr_data,
    output logic              cmp_en,
    output logic              cmp_bit
);
    logic gate;

    always_comb begin
        gate    = active && (!pred || mask_bit);
        wr_en   = 1'b0;
        wr_data = '0;
        cmp_en  = 1'b0;
        cmp_bit = src_a > scalar;
        case (op)
            OP_VADD: begin
                wr_en   = gate;
                wr_data = src_a + src_b;
            end
            OP_VMUL: begin
                wr_en   = gate;
                wr_data = src_a * src_b;
            end
            OP_GATHER: begin
                wr_en   = active;
                wr_data = idx_ok ? gath_val : '0;
            end
            OP_CMPGT: cmp_en = active;
            default: ;
        endcase
    end
endmodule

// File: rtl/vpu_core.sv
module vpu_core
    import vpu_pkg::*;
#(
    parameter int LANES = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                start,
    input  logic [3:0]          op,
    input  logic                pred,
    input  logic [VREG_AW-1:0]  vd,
    input  logic [VREG_AW-1:0]  vs1,
    input  logic [VREG_AW-1:0]  vs2,
    input  logic [EIDX_W-1:0]   eidx,
    input  logic [ELEM_W-1:0]   scalar_in,
    output logic                busy,
    output logic                done,
    output logic [ELEM_W-1:0]   scalar_res,
    output logic [VL_W-1:0]     vl_out,
    output logic [NUM_ELEM-1:0] mask_out
);
    localparam int RF_AW = VREG_AW + EIDX_W;
    localparam int DEPTH = NUM_VREG * NUM_ELEM;

    vinstr_t               cur_q, issue;
    logic                  busy_q, done_q;
    logic [VL_W-1:0]       base_q, vl_q;
    logic [NUM_ELEM-1:0]   mask_q;
    logic [ELEM_W-1:0]     acc_q, res_q, fold;

    logic [LANES-1:0][RF_AW-1:0]  ra_a, ra_b, ra_c, wa;
    logic [LANES-1:0][ELEM_W-1:0] rd_a, rd_b, rd_c, wd, lane_wd;
    logic [LANES-1:0][VL_W-1:0]   pos;
    logic [LANES-1:0]             we, lane_we, act, idx_ok, mbit, cmp_en, cmp_bit;
    logic                         vec_op, red_op, is_last;

    always_comb begin
        issue.op   = vop_e'(op);
        issue.pred = pred;
        issue.vd   = vd;
        issue.vs1  = vs1;
        issue.vs2  = vs2;
        issue.eidx = eidx;
        issue.sc   = scalar_in;
    end

    always_comb begin
        vec_op  = busy_q && is_vector_op(cur_q.op);
        red_op  = busy_q && is_fold_op(cur_q.op);
        is_last = !vec_op || ((base_q + VL_W'(LANES)) >= vl_q);
        for (int l = 0; l < LANES; l++) begin
            pos[l]    = base_q + VL_W'(l);
            act[l]    = vec_op && (pos[l] < vl_q);
            mbit[l]   = mask_q[pos[l][EIDX_W-1:0]];
            ra_a[l]   = {cur_q.vs1, pos[l][EIDX_W-1:0]};
            ra_b[l]   = {cur_q.vs2, pos[l][EIDX_W-1:0]};
            ra_c[l]   = {cur_q.vs1, rd_b[l][EIDX_W-1:0]};
            idx_ok[l] = rd_b[l] < {{(ELEM_W-VL_W){1'b0}}, vl_q};
            we[l]     = lane_we[l];
            wa[l]     = {cur_q.vd, pos[l][EIDX_W-1:0]};
            wd[l]     = lane_wd[l];
        end
        // Scalar-side element access shares lane 0 ports
        if (cur_q.op == OP_EXT) ra_a[0] = {cur_q.vs1, cur_q.eidx};
        if (busy_q && cur_q.op == OP_INS) begin
            we[0] = 1'b1;
            wa[0] = {cur_q.vd, cur_q.eidx};
            wd[0] = cur_q.sc;
        end
    end

    always_comb begin
        fold = acc_q;
        for (int l = 0; l < LANES; l++) begin
            if (act[l]) fold = fold_step(cur_q.op, fold, rd_a[l]);
        end
    end

    vpu_regfile #(
        .LANES(LANES), .AW(RF_AW), .DW(ELEM_W), .DEPTH(DEPTH)
    ) u_rf (
        .clk (clk),
        .ra_a(ra_a), .ra_b(ra_b), .ra_c(ra_c),
        .rd_a(rd_a), .rd_b(rd_b), .rd_c(rd_c),
        .we  (we),   .wa  (wa),   .wd  (wd)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        vpu_lane u_lane (
            .op      (cur_q.op),
            .pred    (cur_q.pred),
            .active  (act[g]),
            .mask_bit(mbit[g]),
            .src_a   (rd_a[g]),
            .src_b   (rd_b[g]),
            .gath_val(rd_c[g]),
            .idx_ok  (idx_ok[g]),
            .scalar  (cur_q.sc),
            .wr_en   (lane_we[g]),
            .wr_data (lane_wd[g]),
            .cmp_en  (cmp_en[g]),
            .cmp_bit (cmp_bit[g])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            done_q <= 1'b0;
            cur_q  <= '0;
            base_q <= '0;
            vl_q   <= VL_W'(NUM_ELEM);
            mask_q <= '0;
            acc_q  <= '0;
            res_q  <= '0;
        end else begin
            done_q <= 1'b0;
            if (!busy_q) begin
                if (start) begin
                    cur_q  <= issue;
                    busy_q <= 1'b1;
                    base_q <= '0;
                    acc_q  <= fold_seed(issue.op);
                end
            end else begin
                for (int l = 0; l < LANES; l++) begin
                    if (cmp_en[l]) mask_q[pos[l][EIDX_W-1:0]] <= cmp_bit[l];
                end
                if (red_op) acc_q <= fold;
                if (cur_q.op == OP_SETLEN)
                    vl_q <= (cur_q.sc > ELEM_W'(NUM_ELEM)) ? VL_W'(NUM_ELEM)
                                                           : cur_q.sc[VL_W-1:0];
                if (cur_q.op == OP_EXT) res_q <= rd_a[0];
                if (is_last) begin
                    busy_q <= 1'b0;
                    done_q <= 1'b1;
                    if (red_op) res_q <= fold;
                end else begin
                    base_q <= base_q + VL_W'(LANES);
                end
            end
        end
    end

    assign busy       = busy_q;
    assign done       = done_q;
    assign scalar_res = res_q;
    assign vl_out     = vl_q;
    assign mask_out   = mask_q;
endmodule

// File: rtl/vpu_core_chk.sv
module vpu_core_chk
    import vpu_pkg::*;
(
    input logic                clk,
    input logic                rst,
    input logic                busy,
    input logic                done,
    input logic [ELEM_W-1:0]   scalar_res,
    input logic [VL_W-1:0]     vl_out,
    input logic [NUM_ELEM-1:0] mask_out
);
    assert_done_single_R9: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_done_after_busy_R9: assert property (@(posedge clk) disable iff (rst)
        done |-> (!busy && $past(busy)));

    assert_len_bounded_R2: assert property (@(posedge clk) disable iff (rst)
        vl_out <= VL_W'(NUM_ELEM));

    assert_len_idle_stable_R2: assert property (@(posedge clk) disable iff (rst)
        !$past(busy) |-> $stable(vl_out));

    assert_mask_idle_stable_R5: assert property (@(posedge clk) disable iff (rst)
        !$past(busy) |-> $stable(mask_out));

    assert_result_idle_stable_R6: assert property (@(posedge clk) disable iff (rst)
        !$past(busy) |-> $stable(scalar_res));
endmodule

bind vpu_core vpu_core_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .busy      (busy),
    .done      (done),
    .scalar_res(scalar_res),
    .vl_out    (vl_out),
    .mask_out  (mask_out)
);

// File: tb/vpu_core_tb.sv
module vpu_core_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [3:0]  op = '0;
    logic        pred = 1'b0;
    logic [2:0]  vd = '0, vs1 = '0, vs2 = '0;
    logic [5:0]  eidx = '0;
    logic [63:0] scalar_in = '0;
    logic        busy, done;
    logic [63:0] scalar_res, mask_out;
    logic [6:0]  vl_out;

    int n_chk = 0;
    int n_err = 0;

    logic [63:0] mdl_rf [8][64];
    logic [63:0] mdl_mask = '0;

    always #2.5 clk = ~clk;

    vpu_core u_dut (
        .clk(clk), .rst(rst), .start(start), .op(op), .pred(pred),
        .vd(vd), .vs1(vs1), .vs2(vs2), .eidx(eidx), .scalar_in(scalar_in),
        .busy(busy), .done(done), .scalar_res(scalar_res),
        .vl_out(vl_out), .mask_out(mask_out)
    );

    typedef struct packed {
        logic [3:0]  op;
        logic [7:0]  len;
        logic [2:0]  d;
        logic [2:0]  a;
        logic [2:0]  b;
        logic        pr;
        logic [63:0] sc;
    } step_t;

    localparam int NSTEP = 12;
    localparam step_t STEPS [NSTEP] = '{
        '{4'd0, 8'd64, 3'd2, 3'd0, 3'd1, 1'b0, 64'd0},
        '{4'd2, 8'd37, 3'd0, 3'd0, 3'd0, 1'b0, 64'h8000_0000_0000_0000},
        '{4'd1, 8'd37, 3'd3, 3'd0, 3'd1, 1'b1, 64'd0},
        '{4'd0, 8'd10, 3'd4, 3'd1, 3'd2, 1'b0, 64'd0},
        '{4'd3, 8'd64, 3'd0, 3'd0, 3'd0, 1'b0, 64'd0},
        '{4'd4, 8'd23, 3'd0, 3'd1, 3'd0, 1'b0, 64'd0},
        '{4'd5, 8'd64, 3'd0, 3'd2, 3'd0, 1'b0, 64'd0},
        '{4'd3, 8'd0,  3'd0, 3'd0, 3'd0, 1'b0, 64'd0},
        '{4'd6, 8'd50, 3'd5, 3'd0, 3'd7, 1'b0, 64'd0},
        '{4'd2, 8'd5,  3'd0, 3'd1, 3'd0, 1'b0, 64'd0},
        '{4'd0, 8'd0,  3'd6, 3'd0, 3'd1, 1'b0, 64'd0},
        '{4'd5, 8'd0,  3'd0, 3'd3, 3'd0, 1'b0, 64'd0}
    };

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] init_val(int r, int i);
        if (r == 7) return 64'((i * 37 + 5) % 80);
        return (64'(r * 64 + i + 1) * 64'h9E37_79B9_7F4A_7C15) ^ (64'(i) << 17);
    endfunction

    function automatic int exp_cycles(logic [3:0] o, int len);
        if (o > 4'd6) return 1;
        if (len == 0) return 1;
        return (len + 3) / 4;
    endfunction

    // Issue one instruction and return the number of falling edges until done
    task automatic issue(input logic [3:0] o, input logic [2:0] d, input logic [2:0] a,
                         input logic [2:0] b, input logic [5:0] e, input logic pr,
                         input logic [63:0] sc, output int lat);
        @(negedge clk);
        op = o; vd = d; vs1 = a; vs2 = b; eidx = e; pred = pr; scalar_in = sc;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lat = 0;
        while (!done && lat < 300) begin
            @(negedge clk);
            lat++;
        end
    endtask

    task automatic set_len(input int len);
        int lat;
        logic [63:0] expv;
        issue(4'd7, 3'd0, 3'd0, 3'd0, 6'd0, 1'b0, 64'(len), lat);
        expv = (len > 64) ? 64'd64 : 64'(len);
        chk(vl_out == expv[6:0], "R2 length write", 64'(vl_out), expv);
        chk(lat == 1, "R9 set-length latency", 64'(lat), 64'd1);
    endtask

    task automatic check_reg(input int r, input string req);
        int lat;
        for (int i = 0; i < 64; i++) begin
            issue(4'd9, 3'd0, 3'(r), 3'd0, 6'(i), 1'b0, 64'd0, lat);
            chk(scalar_res == mdl_rf[r][i], req, scalar_res, mdl_rf[r][i]);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        int lat;
        logic [63:0] expv;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        chk(busy == 1'b0, "R1 busy", 64'(busy), 64'd0);
        chk(done == 1'b0, "R1 done", 64'(done), 64'd0);
        chk(scalar_res == 64'd0, "R1 scalar", scalar_res, 64'd0);
        chk(mask_out == 64'd0, "R1 mask", mask_out, 64'd0);
        chk(vl_out == 7'd64, "R1 length", 64'(vl_out), 64'd64);

        // R8 load every register through insert
        for (int r = 0; r < 8; r++) begin
            for (int i = 0; i < 64; i++) begin
                mdl_rf[r][i] = init_val(r, i);
                issue(4'd8, 3'(r), 3'd0, 3'd0, 6'(i), 1'b0, init_val(r, i), lat);
                if (r == 0 && i == 0) chk(lat == 1, "R9 insert latency", 64'(lat), 64'd1);
            end
        end
        set_len(3);
        check_reg(0, "R8 insert/extract ignore length");

        // Table-driven instruction walk
        for (int s = 0; s < NSTEP; s++) begin
            step_t st;
            int n;
            logic [63:0] acc;
            logic [63:0] tmp [64];
            st = STEPS[s];
            n = int'(st.len);
            set_len(n);
            acc = (st.op == 4'd3) ? '1 : '0;
            for (int i = 0; i < 64; i++) tmp[i] = mdl_rf[st.d][i];
            for (int i = 0; i < n; i++) begin
                case (st.op)
                    4'd0: if (!st.pr || mdl_mask[i]) tmp[i] = mdl_rf[st.a][i] + mdl_rf[st.b][i];
                    4'd1: if (!st.pr || mdl_mask[i]) tmp[i] = mdl_rf[st.a][i] * mdl_rf[st.b][i];
                    4'd2: mdl_mask[i] = mdl_rf[st.a][i] > st.sc;
                    4'd3: if (mdl_rf[st.a][i] < acc) acc = mdl_rf[st.a][i];
                    4'd4: if (mdl_rf[st.a][i] > acc) acc = mdl_rf[st.a][i];
                    4'd5: acc = acc + mdl_rf[st.a][i];
                    4'd6: tmp[i] = (mdl_rf[st.b][i] < 64'(n)) ? mdl_rf[st.a][mdl_rf[st.b][i][5:0]] : 64'd0;
                    default: ;
                endcase
            end
            for (int i = 0; i < 64; i++) mdl_rf[st.d][i] = tmp[i];

            issue(st.op, st.d, st.a, st.b, 6'd0, st.pr, st.sc, lat);
            chk(lat == exp_cycles(st.op, n), "R9 vector latency", 64'(lat), 64'(exp_cycles(st.op, n)));

            case (st.op)
                4'd0, 4'd1: check_reg(int'(st.d), st.pr ? "R4 predicated arithmetic" : "R3 vertical arithmetic");
                4'd6:       check_reg(int'(st.d), "R7 gather");
                4'd2:       chk(mask_out == mdl_mask, "R5 compare mask", mask_out, mdl_mask);
                default:    chk(scalar_res == acc, "R6 fold result", scalar_res, acc);
            endcase
        end

        // R2 saturation and exact upper bound
        set_len(200);
        set_len(64);

        // R10 start while busy is ignored
        @(negedge clk);
        op = 4'd0; vd = 3'd6; vs1 = 3'd0; vs2 = 3'd1; pred = 1'b0; scalar_in = '0;
        start = 1'b1;
        @(negedge clk);
        op = 4'd7; scalar_in = 64'd3;
        @(negedge clk);
        start = 1'b0;
        lat = 1;
        while (!done && lat < 300) begin
            @(negedge clk);
            lat++;
        end
        chk(lat == 16, "R10 busy run length", 64'(lat), 64'd16);
        chk(vl_out == 7'd64, "R10 length untouched", 64'(vl_out), 64'd64);
        @(negedge clk);
        chk(busy == 1'b0, "R10 no second instruction", 64'(busy), 64'd0);
        expv = mdl_rf[0][63] + mdl_rf[1][63];
        issue(4'd9, 3'd0, 3'd6, 3'd0, 6'd63, 1'b0, 64'd0, lat);
        chk(scalar_res == expv, "R3 last element written", scalar_res, expv);

        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end
endmodule